// File: doc/BRIEF.md
# Source Operand Evaluator with Built-in Constants

This unit works out where the source operand of a two-operand instruction comes from. Each request carries the 2-bit source mode, the 4-bit source register number, a byte/word flag, the current value of that register, the program counter and the extension word that follows the opcode. One clock later it returns one of three kinds of result: the register value itself, a constant that is wired into the hardware, or the effective address that memory must be read at. Alongside it returns the post-increment value for the base register, and two flags that tell the fetch logic whether an extension word is used and whether a memory read is due.

Two register numbers have special meanings. The program counter turns the indexed mode into a PC-relative address and the post-increment mode into an immediate fetch. The status register turns the indexed mode into an absolute address and its two indirect modes into constants. Register 3 only ever yields constants. The register file and the memory are outside this unit. The caller supplies, as the PC, the address of the extension word. That is the value before the PC is stepped past that word.

Top module: `srcop_eval`

## Requirements
- R1: A synchronous active-high reset clears every output to zero, with out_valid low.
- R2: out_valid is high exactly one cycle after a cycle with in_valid high and low otherwise. The result outputs keep their last value while in_valid is low.
- R3: Mode 00 on any register other than register 3 returns kind 00 (register value) with the register value as the operand. This includes the status register. Both flags and wb_en are low.
- R4: In byte mode (byte_op high), a register value or a constant is returned with bits 15:8 cleared.
- R5: Mode 01 on a general register returns kind 10 (address) with operand = register value + extension word, modulo 2^16. need_ext and need_mem are high and wb_en is low.
- R6: Mode 01 on register 0 (PC) returns the address PC + extension word, with need_ext and need_mem high.
- R7: Mode 01 on register 2 (status) returns the extension word itself as the address, with need_ext and need_mem high.
- R8: Mode 10 on a general register returns the register value as the address, with need_mem high and need_ext low.
- R9: Mode 11 on a general register returns the register value as the address with need_mem high. It also sets wb_en and wb_reg = the register number, with wb_val = register value + 1 in byte mode or + 2 in word mode, modulo 2^16.
- R10: Mode 11 on register 0 (immediate) returns the PC as the address with need_ext and need_mem high. It writes back register 0 with PC + 2, in byte mode as well.
- R11: Register 3 yields the constants 0x0000, 0x0001, 0x0002 and 0xFFFF for modes 00, 01, 10 and 11. Register 2 yields 0x0004 for mode 10 and 0x0008 for mode 11. Every constant has kind 01, with need_ext, need_mem and wb_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| src_mode | input | 2 | Source addressing mode |
| src_reg | input | 4 | Source register number |
| byte_op | input | 1 | 1 = byte operation, 0 = word |
| reg_val | input | 16 | Current value of the source register |
| pc_val | input | 16 | PC, pointing at the extension word |
| ext_word | input | 16 | Extension word following the opcode |
| out_valid | output | 1 | Result strobe |
| out_kind | output | 2 | 00 register value, 01 constant, 10 address |
| out_operand | output | 16 | Value or effective address |
| out_need_ext | output | 1 | Extension word is consumed |
| out_need_mem | output | 1 | Memory read at out_operand is needed |
| out_wb_en | output | 1 | Base register update is due |
| out_wb_reg | output | 4 | Register to update |
| out_wb_val | output | 16 | New value for that register |

## Verification
The assertions assume that src_mode, src_reg, byte_op, reg_val and ext_word are valid whenever in_valid is high, and that the request stays stable through the clock edge that samples it. The stimulus drives every input on the falling edge and holds it through the following rising edge. It raises in_valid for single cycles only, so the one-cycle latency and the hold behaviour are seen in isolation. The general-register cases use registers 4 and 15, and the PC and status-register cases are applied directly. This keeps each special register and mode pairing separate from the plain post-increment path that the step assertion covers.

// File: rtl/srcop_pkg.sv
package srcop_pkg;
  typedef enum logic [1:0] {
    SRC_REG   = 2'b00,
    SRC_CONST = 2'b01,
    SRC_ADDR  = 2'b10
  } src_kind_e;

  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'b00,
    MODE_INDEX   = 2'b01,
    MODE_INDIR   = 2'b10,
    MODE_POSTINC = 2'b11
  } src_mode_e;
endpackage

// File: rtl/srcop_const_gen.sv
module srcop_const_gen
  import srcop_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RN_W   = 4,
  parameter int SR_IDX = 2,
  parameter int CG_IDX = 3
) (
  input  logic [1:0]        mode,
  input  logic [RN_W-1:0]   rn,
  output logic              is_const,
  output logic [DATA_W-1:0] const_val
);
  localparam logic [RN_W-1:0] SR_N = RN_W'(SR_IDX);
  localparam logic [RN_W-1:0] CG_N = RN_W'(CG_IDX);

  always_comb begin
    is_const  = 1'b0;
    const_val = '0;
    if (rn == CG_N) begin
      is_const = 1'b1;
      unique case (mode)
        MODE_DIRECT:  const_val = DATA_W'(0);
        MODE_INDEX:   const_val = DATA_W'(1);
        MODE_INDIR:   const_val = DATA_W'(2);
        default:      const_val = '1;
      endcase
    end else if (rn == SR_N && mode[1]) begin
      is_const  = 1'b1;
      const_val = (mode == MODE_INDIR) ? DATA_W'(4) : DATA_W'(8);
    end
  end
endmodule

// File: rtl/srcop_addr_calc.sv
module srcop_addr_calc
  import srcop_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RN_W   = 4,
  parameter int PC_IDX = 0,
  parameter int SR_IDX = 2
) (
  input  logic [1:0]        mode,
  input  logic [RN_W-1:0]   rn,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] pc_val,
  input  logic [DATA_W-1:0] ext_word,
  output logic [DATA_W-1:0] addr,
  output logic              use_ext
);
  localparam logic [RN_W-1:0] PC_N = RN_W'(PC_IDX);
  localparam logic [RN_W-1:0] SR_N = RN_W'(SR_IDX);

  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] offset;

  always_comb begin
    base   = reg_val;
    offset = '0;
    if (rn == PC_N) base = pc_val;
    if (mode == MODE_INDEX) begin
      offset = ext_word;
      if (rn == SR_N) base = '0;
    end
  end

  // one shared adder for every address form
  assign addr    = base + offset;
  assign use_ext = (mode == MODE_INDEX) || (mode == MODE_POSTINC && rn == PC_N);
endmodule

// File: rtl/srcop_incr.sv
module srcop_incr #(
  parameter int DATA_W = 16,
  parameter int RN_W   = 4,
  parameter int PC_IDX = 0
) (
  input  logic [RN_W-1:0]   rn,
  input  logic              byte_op,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] pc_val,
  output logic [DATA_W-1:0] next_val
);
  localparam logic [RN_W-1:0] PC_N = RN_W'(PC_IDX);

  logic              is_pc;
  logic [DATA_W-1:0] step;

  assign is_pc    = (rn == PC_N);
  // the PC stays word aligned
  assign step     = (byte_op && !is_pc) ? DATA_W'(1) : DATA_W'(2);
  assign next_val = (is_pc ? pc_val : reg_val) + step;
endmodule

// File: rtl/srcop_eval.sv
module srcop_eval
  import srcop_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RN_W   = 4,
  parameter int PC_IDX = 0,
  parameter int SR_IDX = 2,
  parameter int CG_IDX = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        src_mode,
  input  logic [RN_W-1:0]   src_reg,
  input  logic              byte_op,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] pc_val,
  input  logic [DATA_W-1:0] ext_word,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [DATA_W-1:0] out_operand,
  output logic              out_need_ext,
  output logic              out_need_mem,
  output logic              out_wb_en,
  output logic [RN_W-1:0]   out_wb_reg,
  output logic [DATA_W-1:0] out_wb_val
);
  localparam logic [RN_W-1:0]   PC_N      = RN_W'(PC_IDX);
  localparam logic [RN_W-1:0]   SR_N      = RN_W'(SR_IDX);
  localparam logic [RN_W-1:0]   CG_N      = RN_W'(CG_IDX);
  localparam logic [DATA_W-1:0] BYTE_MASK = DATA_W'(8'hFF);

  logic              is_const;
  logic [DATA_W-1:0] const_val;
  logic [DATA_W-1:0] addr;
  logic              use_ext;
  logic [DATA_W-1:0] inc_val;

  srcop_const_gen #(
    .DATA_W(DATA_W), .RN_W(RN_W), .SR_IDX(SR_IDX), .CG_IDX(CG_IDX)
  ) u_const (
    .mode(src_mode), .rn(src_reg), .is_const(is_const), .const_val(const_val)
  );

  srcop_addr_calc #(
    .DATA_W(DATA_W), .RN_W(RN_W), .PC_IDX(PC_IDX), .SR_IDX(SR_IDX)
  ) u_addr (
    .mode(src_mode), .rn(src_reg), .reg_val(reg_val), .pc_val(pc_val),
    .ext_word(ext_word), .addr(addr), .use_ext(use_ext)
  );

  srcop_incr #(
    .DATA_W(DATA_W), .RN_W(RN_W), .PC_IDX(PC_IDX)
  ) u_incr (
    .rn(src_reg), .byte_op(byte_op), .reg_val(reg_val), .pc_val(pc_val),
    .next_val(inc_val)
  );

  logic [1:0]        nx_kind;
  logic [DATA_W-1:0] nx_operand;
  logic              nx_need_ext;
  logic              nx_need_mem;
  logic              nx_wb_en;
  logic [DATA_W-1:0] value_raw;

  always_comb begin
    value_raw   = is_const ? const_val : reg_val;
    nx_need_ext = 1'b0;
    nx_need_mem = 1'b0;
    nx_wb_en    = 1'b0;
    if (is_const) begin
      nx_kind    = SRC_CONST;
      nx_operand = byte_op ? (value_raw & BYTE_MASK) : value_raw;
    end else if (src_mode == MODE_DIRECT) begin
      nx_kind    = SRC_REG;
      nx_operand = byte_op ? (value_raw & BYTE_MASK) : value_raw;
    end else begin
      nx_kind     = SRC_ADDR;
      nx_operand  = addr;
      nx_need_ext = use_ext;
      nx_need_mem = 1'b1;
      nx_wb_en    = (src_mode == MODE_POSTINC);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_kind     <= '0;
      out_operand  <= '0;
      out_need_ext <= 1'b0;
      out_need_mem <= 1'b0;
      out_wb_en    <= 1'b0;
      out_wb_reg   <= '0;
      out_wb_val   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_kind     <= nx_kind;
        out_operand  <= nx_operand;
        out_need_ext <= nx_need_ext;
        out_need_mem <= nx_need_mem;
        out_wb_en    <= nx_wb_en;
        out_wb_reg   <= nx_wb_en ? src_reg : '0;
        out_wb_val   <= nx_wb_en ? inc_val : '0;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_operand) && $stable(out_kind)); // R2
  AST_DIRECT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    in_valid && src_mode == MODE_DIRECT |=> !out_need_mem && !out_need_ext && !out_wb_en); // R3
  AST_BYTE_TRUNC: assert property (@(posedge clk) disable iff (rst)
    in_valid && byte_op && src_mode == MODE_DIRECT |=> out_operand[DATA_W-1:8] == '0); // R4
  AST_ABS_ADDR: assert property (@(posedge clk) disable iff (rst)
    in_valid && src_mode == MODE_INDEX && src_reg == SR_N |=> out_operand == $past(ext_word)); // R7
  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (rst)
    in_valid && src_mode == MODE_POSTINC && src_reg != PC_N && src_reg != SR_N && src_reg != CG_N
    |=> out_wb_en && out_wb_val == $past(reg_val) + ($past(byte_op) ? DATA_W'(1) : DATA_W'(2))); // R9
  AST_CONST_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    in_valid && src_reg == CG_N |=> out_kind == SRC_CONST && !out_need_mem && !out_need_ext && !out_wb_en); // R11
endmodule

// File: tb/srcop_eval_tb.sv
module srcop_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  src_mode = '0;
  logic [3:0]  src_reg = '0;
  logic        byte_op = 1'b0;
  logic [15:0] reg_val = '0;
  logic [15:0] pc_val = '0;
  logic [15:0] ext_word = '0;
  logic        out_valid;
  logic [1:0]  out_kind;
  logic [15:0] out_operand;
  logic        out_need_ext;
  logic        out_need_mem;
  logic        out_wb_en;
  logic [3:0]  out_wb_reg;
  logic [15:0] out_wb_val;

  always #5 clk = ~clk;

  srcop_eval dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_mode(src_mode), .src_reg(src_reg),
    .byte_op(byte_op), .reg_val(reg_val), .pc_val(pc_val), .ext_word(ext_word),
    .out_valid(out_valid), .out_kind(out_kind), .out_operand(out_operand),
    .out_need_ext(out_need_ext), .out_need_mem(out_need_mem), .out_wb_en(out_wb_en),
    .out_wb_reg(out_wb_reg), .out_wb_val(out_wb_val)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  mode;
    logic [3:0]  rn;
    logic        byt;
    logic [15:0] rv;
    logic [15:0] pc;
    logic [15:0] ext;
    logic [1:0]  kind;
    logic [15:0] op;
    logic        e;
    logic        m;
    logic        w;
    logic [15:0] wbv;
  } vec_t;

  localparam int NV = 19;
  // kind: 0 register value, 1 constant, 2 address
  localparam vec_t VECS [NV] = '{
    '{8'd3,  2'd0, 4'd4,  1'b0, 16'h1234, 16'h8002, 16'h0006, 2'd0, 16'h1234, 1'b0, 1'b0, 1'b0, 16'h0000}, // R3
    '{8'd4,  2'd0, 4'd4,  1'b1, 16'h1234, 16'h8002, 16'h0006, 2'd0, 16'h0034, 1'b0, 1'b0, 1'b0, 16'h0000}, // R4
    '{8'd3,  2'd0, 4'd2,  1'b0, 16'h0005, 16'h8002, 16'h0006, 2'd0, 16'h0005, 1'b0, 1'b0, 1'b0, 16'h0000}, // R3
    '{8'd5,  2'd1, 4'd4,  1'b0, 16'h0200, 16'h8002, 16'h0006, 2'd2, 16'h0206, 1'b1, 1'b1, 1'b0, 16'h0000}, // R5
    '{8'd6,  2'd1, 4'd0,  1'b0, 16'h5555, 16'h800C, 16'h0012, 2'd2, 16'h801E, 1'b1, 1'b1, 1'b0, 16'h0000}, // R6
    '{8'd7,  2'd1, 4'd2,  1'b0, 16'h0005, 16'h8010, 16'h801E, 2'd2, 16'h801E, 1'b1, 1'b1, 1'b0, 16'h0000}, // R7
    '{8'd8,  2'd2, 4'd4,  1'b0, 16'h0200, 16'h8002, 16'h0006, 2'd2, 16'h0200, 1'b0, 1'b1, 1'b0, 16'h0000}, // R8
    '{8'd9,  2'd3, 4'd4,  1'b0, 16'h0200, 16'h8002, 16'h0006, 2'd2, 16'h0200, 1'b0, 1'b1, 1'b1, 16'h0202}, // R9
    '{8'd9,  2'd3, 4'd4,  1'b1, 16'h0200, 16'h8002, 16'h0006, 2'd2, 16'h0200, 1'b0, 1'b1, 1'b1, 16'h0201}, // R9
    '{8'd10, 2'd3, 4'd0,  1'b1, 16'h1111, 16'h8014, 16'h0064, 2'd2, 16'h8014, 1'b1, 1'b1, 1'b1, 16'h8016}, // R10
    '{8'd11, 2'd0, 4'd3,  1'b0, 16'h1234, 16'h8002, 16'h0006, 2'd1, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R11
    '{8'd11, 2'd1, 4'd3,  1'b0, 16'h1234, 16'h8002, 16'hABCD, 2'd1, 16'h0001, 1'b0, 1'b0, 1'b0, 16'h0000}, // R11
    '{8'd11, 2'd2, 4'd3,  1'b0, 16'h1234, 16'h8002, 16'h0006, 2'd1, 16'h0002, 1'b0, 1'b0, 1'b0, 16'h0000}, // R11
    '{8'd11, 2'd3, 4'd3,  1'b0, 16'h1234, 16'h8002, 16'h0006, 2'd1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 16'h0000}, // R11
    '{8'd4,  2'd3, 4'd3,  1'b1, 16'h1234, 16'h8002, 16'h0006, 2'd1, 16'h00FF, 1'b0, 1'b0, 1'b0, 16'h0000}, // R4
    '{8'd11, 2'd2, 4'd2,  1'b0, 16'h1234, 16'h8002, 16'h0006, 2'd1, 16'h0004, 1'b0, 1'b0, 1'b0, 16'h0000}, // R11
    '{8'd11, 2'd3, 4'd2,  1'b0, 16'h1234, 16'h8002, 16'h0006, 2'd1, 16'h0008, 1'b0, 1'b0, 1'b0, 16'h0000}, // R11
    '{8'd9,  2'd3, 4'd15, 1'b0, 16'hFFFF, 16'h8002, 16'h0006, 2'd2, 16'hFFFF, 1'b0, 1'b1, 1'b1, 16'h0001}, // R9
    '{8'd5,  2'd1, 4'd15, 1'b0, 16'hFFF0, 16'h8002, 16'h0020, 2'd2, 16'h0010, 1'b1, 1'b1, 1'b0, 16'h0000}  // R5
  };

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  function automatic logic [41:0] outs();
    return {out_valid, out_kind, out_operand, out_need_ext, out_need_mem,
            out_wb_en, out_wb_reg, out_wb_val};
  endfunction

  task automatic check(input string tag, input logic [41:0] act, input logic [41:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [3:0] r, input logic b,
                       input logic [15:0] rv, input logic [15:0] pc, input logic [15:0] ex);
    @(negedge clk);
    src_mode = m; src_reg = r; byte_op = b; reg_val = rv; pc_val = pc; ext_word = ex;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 reset", outs(), 42'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].mode, VECS[i].rn, VECS[i].byt, VECS[i].rv, VECS[i].pc, VECS[i].ext);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), outs(),
            {1'b1, VECS[i].kind, VECS[i].op, VECS[i].e, VECS[i].m, VECS[i].w,
             (VECS[i].w ? VECS[i].rn : 4'd0), VECS[i].wbv});
    end

    // R2: idle cycle drops out_valid and keeps the last result
    @(negedge clk);
    check("R2 hold", outs(), {1'b0, 2'd2, 16'h0010, 1'b1, 1'b1, 1'b0, 4'd0, 16'h0000});
    // R2: changing inputs without in_valid has no effect
    src_mode = 2'd0; src_reg = 4'd3; reg_val = 16'hBEEF;
    @(negedge clk);
    check("R2 ignore", outs(), {1'b0, 2'd2, 16'h0010, 1'b1, 1'b1, 1'b0, 4'd0, 16'h0000});

    // R10: immediate in word mode
    issue(2'd3, 4'd0, 1'b0, 16'h0000, 16'hFFFE, 16'h0000);
    check("R10 word wrap", outs(), {1'b1, 2'd2, 16'hFFFE, 1'b1, 1'b1, 1'b1, 4'd0, 16'h0000});

    // R1: reset in the middle clears a live result
    issue(2'd3, 4'd4, 1'b0, 16'h0300, 16'h8000, 16'h0000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset", outs(), 42'd0);
    rst = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule